// File: doc/BRIEF.md
# Secure configuration control register

This block holds the 32-bit security configuration word owned by the most privileged exception level, together with the access port that guards it. A requester presents a select strobe with the current exception level, a read/write flag and write data. The block checks privilege against the hypervisor and monitor configuration bits it is given. It returns, one cycle later, read data and an outcome: accepted, undefined, or a trap to a named level with a syndrome code.

The stored word is driven out continuously so that the interrupt routing and trap blocks can decode its fields. Bits that have no implemented function are tied to zero. Elaboration parameters decide whether the hypervisor-call enable, the error-record trap and the early-termination control exist. A guard keeps the non-secure bit from going from 0 to 1 while the trap-general-exceptions input is set.

Top module: `sec_cfg_reg`

## Requirements
- R1: Bits 31:16, bit 14 and bits 11:10 of the word always read as zero; writing ones to them has no effect.
- R2: A write from level 3 loads the implemented fields from the write data, where the field bits are 15, 13, 12, 9, 8, 7, 6, 5, 4, 3, 2, 1 and 0 (non-secure bit at 0). A read from level 3 returns the word with outcome OK (code 0).
- R3: While reset is low the word is all zeros and no response is reported.
- R4: Any access from level 0 or level 2 gives outcome UNDEF (code 1).
- R5: From level 1 the first matching rule wins. (a) Level 2 is enabled, runs 64-bit and the register-trap bit is set: TRAP_L2 (code 2). (b) Level 2 is enabled, runs 32-bit and the trap bit is set: HYP_TRAP (code 3). (c) Level 2 runs 64-bit and the monitor {NS, EEL2} pair is 01: TRAP_L2. (d) Level 3 runs 64-bit and monitor NS is 0: TRAP_L3 (code 4). (e) Otherwise: UNDEF.
- R6: Trap outcomes (codes 2, 3, 4) carry syndrome 0x03. Other outcomes carry syndrome 0.
- R7: While TGE is set, a level 3 write that would move the non-secure bit from 0 to 1 leaves it at 0, and the rest of the write still takes effect. A 1-to-0 change is still allowed.
- R8: An access that is not OK leaves the word unchanged and returns read data 0.
- R9: The response valid goes high in the cycle after a strobe for exactly one cycle.
- R10: With the features absent, bit 8 (no level 2), bit 15 (no error records) and bit 6 (no early-termination control) read as zero after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| cur_el | input | 2 | Exception level of the requester |
| wdata | input | 32 | Write data |
| hyp_t1 | input | 1 | Hypervisor register-trap bit for this register |
| hyp_tge | input | 1 | Trap-general-exceptions bit |
| l2_enabled | input | 1 | Level 2 is enabled in the current state |
| l2_narrow | input | 1 | Level 2 uses the 32-bit execution state |
| l3_narrow | input | 1 | Level 3 uses the 32-bit execution state |
| mon_ns | input | 1 | Non-secure bit of the 64-bit monitor configuration |
| mon_eel2 | input | 1 | Secure level 2 enable of the 64-bit monitor configuration |
| resp_valid | output | 1 | Response valid, one cycle |
| resp_kind | output | 3 | Outcome: 0 OK, 1 UNDEF, 2 TRAP_L2, 3 HYP_TRAP, 4 TRAP_L3 |
| resp_synd | output | 6 | Syndrome code of a trap |
| rdata | output | 32 | Read data of an accepted read, else 0 |
| cfg_word | output | 32 | Current configuration word to routing and trap logic |

## Verification
The privilege check is driven with level 1 patterns in which two or more rules match at once. Each expected outcome then shows that the higher-priority rule wins: a set trap bit over the monitor-pair rule, the pair rule over the 64-bit level 3 rule, and a disabled level 2 that skips rule (b). Patterns where each rule just misses (monitor NS high, level 3 in 32-bit state) tell a missing term from a correct UNDEF fall-through. Writes of all ones from every level, with TGE both low and high, tell the reserved masking, the feature masking and the non-secure guard apart from one another and from rejected writes.

// File: rtl/sec_cfg_pkg.sv
// Package: shared types, field positions and the implemented-bit mask
// for the secure configuration control register.
// Assumes a fixed 32-bit word; the feature switches only remove bits.
package sec_cfg_pkg;

    localparam int REG_W  = 32;
    localparam int SYND_W = 6;
    localparam int LVL_W  = 2;
    localparam int KIND_W = 3;

    localparam logic [SYND_W-1:0] TRAP_SYND = 6'h03;

    // Field positions that neighbours decode.
    localparam int POS_NS      = 0;
    localparam int POS_IRQ_MON = 1;
    localparam int POS_FIQ_MON = 2;
    localparam int POS_ABT_MON = 3;
    localparam int POS_FIQ_WR  = 4;
    localparam int POS_ABT_WR  = 5;
    localparam int POS_NOET    = 6;
    localparam int POS_SMC_DIS = 7;
    localparam int POS_HVC_EN  = 8;
    localparam int POS_SFETCH  = 9;
    localparam int POS_WFI_TRP = 12;
    localparam int POS_WFE_TRP = 13;
    localparam int POS_ERR_TRP = 15;

    typedef enum logic [LVL_W-1:0] {
        LVL0 = 2'd0,
        LVL1 = 2'd1,
        LVL2 = 2'd2,
        LVL3 = 2'd3
    } lvl_e;

    typedef enum logic [KIND_W-1:0] {
        OUT_OK       = 3'd0,
        OUT_UNDEF    = 3'd1,
        OUT_TRAP_L2  = 3'd2,
        OUT_HYP_TRAP = 3'd3,
        OUT_TRAP_L3  = 3'd4
    } outcome_e;

    // Builds the mask of bits that hold state, given the feature switches.
    function automatic logic [REG_W-1:0] impl_mask(input bit has_l2,
                                                   input bit has_err,
                                                   input bit has_et);
        logic [REG_W-1:0] m;
        m = '0;
        m[POS_NS]      = 1'b1;
        m[POS_IRQ_MON] = 1'b1;
        m[POS_FIQ_MON] = 1'b1;
        m[POS_ABT_MON] = 1'b1;
        m[POS_FIQ_WR]  = 1'b1;
        m[POS_ABT_WR]  = 1'b1;
        m[POS_NOET]    = has_et;
        m[POS_SMC_DIS] = 1'b1;
        m[POS_HVC_EN]  = has_l2;
        m[POS_SFETCH]  = 1'b1;
        m[POS_WFI_TRP] = 1'b1;
        m[POS_WFE_TRP] = 1'b1;
        m[POS_ERR_TRP] = has_err;
        return m;
    endfunction

    function automatic bit is_trap(input outcome_e k);
        return (k == OUT_TRAP_L2) || (k == OUT_HYP_TRAP) || (k == OUT_TRAP_L3);
    endfunction

endpackage

// File: rtl/sec_cfg_access_chk.sv
// Module: privilege check for one access to the configuration register.
// Purely combinational; assumes the caller registers the verdict.
// Level 3 is accepted, levels 0 and 2 are undefined, and level 1 walks
// an ordered list of trap rules whose first match wins.
module sec_cfg_access_chk
    import sec_cfg_pkg::*;
(
    input  lvl_e     acc_lvl,
    input  logic     hyp_t1,
    input  logic     l2_enabled,
    input  logic     l2_narrow,
    input  logic     l3_narrow,
    input  logic     mon_ns,
    input  logic     mon_eel2,
    output outcome_e verdict
);

    logic rule_l2_wide_t1;
    logic rule_l2_narrow_t1;
    logic rule_mon_pair;
    logic rule_l3_wide;

    // Evaluates each level 1 rule on its own.
    always_comb begin
        rule_l2_wide_t1   = l2_enabled && !l2_narrow && hyp_t1;
        rule_l2_narrow_t1 = l2_enabled &&  l2_narrow && hyp_t1;
        rule_mon_pair     = !l2_narrow && !mon_ns && mon_eel2;
        rule_l3_wide      = !l3_narrow && !mon_ns;
    end

    // Picks the outcome by level, with the level 1 rules in priority order.
    always_comb begin
        verdict = OUT_UNDEF;
        unique case (acc_lvl)
            LVL3: verdict = OUT_OK;
            LVL1: begin
                if (rule_l2_wide_t1)        verdict = OUT_TRAP_L2;
                else if (rule_l2_narrow_t1) verdict = OUT_HYP_TRAP;
                else if (rule_mon_pair)     verdict = OUT_TRAP_L2;
                else if (rule_l3_wide)      verdict = OUT_TRAP_L3;
                else                        verdict = OUT_UNDEF;
            end
            default: verdict = OUT_UNDEF;
        endcase
    end

endmodule

// File: rtl/sec_cfg_store.sv
// Module: storage of the configuration word.
// One flop per implemented bit, built by a generate loop over the mask;
// masked bits are constant zero. The non-secure bit refuses a 0-to-1
// step while TGE is set. Assumes wr_en is already privilege-qualified.
module sec_cfg_store
    import sec_cfg_pkg::*;
#(
    parameter bit HAS_L2  = 1'b1,
    parameter bit HAS_ERR = 1'b1,
    parameter bit HAS_ET  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             tge,
    output logic [REG_W-1:0] word_q
);

    localparam logic [REG_W-1:0] WMASK = impl_mask(HAS_L2, HAS_ERR, HAS_ET);

    // Reserved write bits are deliberately dropped.
    logic unused_wbits;
    assign unused_wbits = ^(wdata & ~WMASK);

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (!WMASK[b]) begin : g_res
            assign word_q[b] = 1'b0;
        end else if (b == POS_NS) begin : g_ns
            logic q;
            // Holds the non-secure bit; blocks a rise while TGE is set.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= 1'b0;
                else if (wr_en && !(tge && !q && wdata[b]))
                    q <= wdata[b];
            end
            assign word_q[b] = q;
        end else begin : g_fld
            logic q;
            // Holds one ordinary field bit.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= 1'b0;
                else if (wr_en)
                    q <= wdata[b];
            end
            assign word_q[b] = q;
        end
    end

    assert_ns_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tge && !word_q[POS_NS]) |=> !word_q[POS_NS])
        else $error("non-secure bit rose while TGE set");

    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[POS_SMC_DIS]) |=> word_q[POS_SMC_DIS])
        else $error("accepted write did not load field");

endmodule

// File: rtl/sec_cfg_resp_reg.sv
// Module: registers the access outcome, syndrome and read data.
// Assumes one strobe per access; the response lasts one cycle and all
// response fields return to zero when no access is pending.
module sec_cfg_resp_reg
    import sec_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  outcome_e          verdict,
    input  logic [REG_W-1:0]  word,
    output logic              resp_valid,
    output outcome_e          resp_kind,
    output logic [SYND_W-1:0] resp_synd,
    output logic [REG_W-1:0]  rdata
);

    // Captures the result of the access presented in this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_kind  <= OUT_OK;
            resp_synd  <= '0;
            rdata      <= '0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) begin
                resp_kind <= verdict;
                resp_synd <= is_trap(verdict) ? TRAP_SYND : '0;
                rdata     <= (verdict == OUT_OK && req_read) ? word : '0;
            end else begin
                resp_kind <= OUT_OK;
                resp_synd <= '0;
                rdata     <= '0;
            end
        end
    end

endmodule

// File: rtl/sec_cfg_reg.sv
// Module: top of the secure configuration control register.
// Combines the privilege check, the word storage and the response
// register. Writes land at the same edge that captures the outcome.
// Assumes acc_valid is a single-cycle strobe per access.
module sec_cfg_reg
    import sec_cfg_pkg::*;
#(
    parameter bit HAS_L2  = 1'b1,
    parameter bit HAS_ERR = 1'b1,
    parameter bit HAS_ET  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [LVL_W-1:0]  cur_el,
    input  logic [REG_W-1:0]  wdata,
    input  logic              hyp_t1,
    input  logic              hyp_tge,
    input  logic              l2_enabled,
    input  logic              l2_narrow,
    input  logic              l3_narrow,
    input  logic              mon_ns,
    input  logic              mon_eel2,
    output logic              resp_valid,
    output logic [KIND_W-1:0] resp_kind,
    output logic [SYND_W-1:0] resp_synd,
    output logic [REG_W-1:0]  rdata,
    output logic [REG_W-1:0]  cfg_word
);

    outcome_e verdict;
    outcome_e kind_q;
    logic     wr_ok;

    sec_cfg_access_chk u_chk (
        .acc_lvl    (lvl_e'(cur_el)),
        .hyp_t1     (hyp_t1),
        .l2_enabled (l2_enabled),
        .l2_narrow  (l2_narrow),
        .l3_narrow  (l3_narrow),
        .mon_ns     (mon_ns),
        .mon_eel2   (mon_eel2),
        .verdict    (verdict)
    );

    // Qualifies a write with an accepted verdict.
    always_comb wr_ok = acc_valid && acc_write && (verdict == OUT_OK);

    sec_cfg_store #(
        .HAS_L2  (HAS_L2),
        .HAS_ERR (HAS_ERR),
        .HAS_ET  (HAS_ET)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ok),
        .wdata  (wdata),
        .tge    (hyp_tge),
        .word_q (cfg_word)
    );

    sec_cfg_resp_reg u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (acc_valid),
        .req_read   (!acc_write),
        .verdict    (verdict),
        .word       (cfg_word),
        .resp_valid (resp_valid),
        .resp_kind  (kind_q),
        .resp_synd  (resp_synd),
        .rdata      (rdata)
    );

    assign resp_kind = kind_q;

    assert_rejected_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cur_el != 2'd3) |=> $stable(cfg_word))
        else $error("rejected access changed the word");

    assert_resp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> resp_valid)
        else $error("response missing after strobe");

    assert_resp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !resp_valid)
        else $error("response without strobe");

    assert_low_levels_undef_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (cur_el == 2'd0 || cur_el == 2'd2)) |=> resp_kind == 3'd1)
        else $error("level 0/2 access not undefined");

    assert_first_rule_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cur_el == 2'd1 && l2_enabled && !l2_narrow && hyp_t1)
        |=> resp_kind == 3'd2)
        else $error("top priority rule lost");

    assert_trap_syndrome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind >= 3'd2) |-> resp_synd == 6'h03)
        else $error("trap without syndrome");

    assert_rejected_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind != 3'd0) |-> rdata == '0)
        else $error("rejected access returned data");

endmodule

// File: tb/sim_sec_cfg_reg.sv
`timescale 1ns/100ps
module sim_sec_cfg_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  cur_el = 2'd0;
    logic [31:0] wdata = '0;
    logic        hyp_t1 = 1'b0;
    logic        hyp_tge = 1'b0;
    logic        l2_enabled = 1'b0;
    logic        l2_narrow = 1'b0;
    logic        l3_narrow = 1'b0;
    logic        mon_ns = 1'b0;
    logic        mon_eel2 = 1'b0;

    logic        resp_valid, resp_valid1;
    logic [2:0]  resp_kind, resp_kind1;
    logic [5:0]  resp_synd, resp_synd1;
    logic [31:0] rdata, rdata1, cfg_word, cfg_word1;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sec_cfg_reg u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .cur_el(cur_el), .wdata(wdata), .hyp_t1(hyp_t1), .hyp_tge(hyp_tge),
        .l2_enabled(l2_enabled), .l2_narrow(l2_narrow), .l3_narrow(l3_narrow),
        .mon_ns(mon_ns), .mon_eel2(mon_eel2), .resp_valid(resp_valid),
        .resp_kind(resp_kind), .resp_synd(resp_synd), .rdata(rdata),
        .cfg_word(cfg_word)
    );

    sec_cfg_reg #(.HAS_L2(1'b0), .HAS_ERR(1'b0), .HAS_ET(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .cur_el(cur_el), .wdata(wdata), .hyp_t1(hyp_t1), .hyp_tge(hyp_tge),
        .l2_enabled(l2_enabled), .l2_narrow(l2_narrow), .l3_narrow(l3_narrow),
        .mon_ns(mon_ns), .mon_eel2(mon_eel2), .resp_valid(resp_valid1),
        .resp_kind(resp_kind1), .resp_synd(resp_synd1), .rdata(rdata1),
        .cfg_word(cfg_word1)
    );

    localparam logic [31:0] KNOWN = 32'h0000_2135;

    // {level, t1, l2_en, l2_narrow, l3_narrow, mon_ns, mon_eel2, write, expected kind}
    localparam int NVEC = 12;
    localparam logic [11:0] VEC [NVEC] = '{
        {2'd0, 6'b011110, 1'b0, 3'd1},
        {2'd2, 6'b110000, 1'b1, 3'd1},
        {2'd1, 6'b110001, 1'b0, 3'd2},
        {2'd1, 6'b111000, 1'b1, 3'd3},
        {2'd1, 6'b100101, 1'b0, 3'd2},
        {2'd1, 6'b010001, 1'b1, 3'd2},
        {2'd1, 6'b011001, 1'b0, 3'd4},
        {2'd1, 6'b010011, 1'b1, 3'd1},
        {2'd1, 6'b011100, 1'b0, 3'd1},
        {2'd1, 6'b101000, 1'b1, 3'd4},
        {2'd3, 6'b110001, 1'b0, 3'd0},
        {2'd1, 6'b100100, 1'b0, 3'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic access(input logic [1:0] el, input logic wr,
                          input logic [31:0] d, input logic tge);
        @(negedge clk);
        cur_el = el; acc_write = wr; wdata = d; hyp_tge = tge; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R3: reset state
        repeat (3) @(negedge clk);
        chk("R3 word in reset", cfg_word, 32'h0);
        chk("R3 valid in reset", {31'h0, resp_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 word after reset", cfg_word, 32'h0);

        // R2: load known value from level 3 and read it back
        access(2'd3, 1'b1, KNOWN, 1'b0);
        chk("R2 write kind", {29'h0, resp_kind}, 32'd0);
        chk("R2 word", cfg_word, KNOWN);
        chk("R9 valid high", {31'h0, resp_valid}, 32'h1);
        @(negedge clk);
        chk("R9 valid one cycle", {31'h0, resp_valid}, 32'h0);

        // R4 R5 R6 R8: vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [2:0] ek;
            logic       w;
            hyp_t1     = VEC[i][9];
            l2_enabled = VEC[i][8];
            l2_narrow  = VEC[i][7];
            l3_narrow  = VEC[i][6];
            mon_ns     = VEC[i][5];
            mon_eel2   = VEC[i][4];
            w          = VEC[i][3];
            ek         = VEC[i][2:0];
            access(VEC[i][11:10], w, 32'hFFFF_FFFF, 1'b0);
            chk($sformatf("R4/R5 kind row %0d", i), {29'h0, resp_kind}, {29'h0, ek});
            chk($sformatf("R6 syndrome row %0d", i), {26'h0, resp_synd},
                (ek >= 3'd2) ? 32'h3 : 32'h0);
            chk($sformatf("R8 word row %0d", i), cfg_word, KNOWN);
            chk($sformatf("R8 rdata row %0d", i), rdata,
                (ek == 3'd0 && !w) ? KNOWN : 32'h0);
        end

        // R1 R2 R10: all-ones write from level 3
        access(2'd3, 1'b1, 32'hFFFF_FFFF, 1'b0);
        chk("R1 reserved masked", cfg_word, 32'h0000_B3FF);
        chk("R10 features absent", cfg_word1, 32'h0000_32BF);
        access(2'd3, 1'b0, 32'h0, 1'b0);
        chk("R2 read back", rdata, 32'h0000_B3FF);
        chk("R10 read back", rdata1, 32'h0000_32BF);

        // R7: non-secure guard
        access(2'd3, 1'b1, 32'h0, 1'b0);
        chk("R7 cleared", cfg_word, 32'h0);
        access(2'd3, 1'b1, 32'hFFFF_FFFF, 1'b1);
        chk("R7 rise blocked", cfg_word, 32'h0000_B3FE);
        access(2'd3, 1'b1, 32'h1, 1'b0);
        chk("R7 rise without TGE", cfg_word, 32'h1);
        access(2'd3, 1'b1, 32'hFFFF_FFFF, 1'b1);
        chk("R7 stays set with TGE", cfg_word, 32'h0000_B3FF);
        access(2'd3, 1'b1, 32'h0, 1'b1);
        chk("R7 fall allowed", cfg_word, 32'h0);

        // R3: reset clears a loaded word
        access(2'd3, 1'b1, KNOWN, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R3 reset clears", cfg_word, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule